// File: doc/BRIEF.md
# Fractional-Rate Second-Tick Generator

This block derives one-second and four-second timing strobes from a real-time-clock count clock. Its `clk` input is the count-rate clock: the crystal clock counted on both edges, so 65536 counts per nominal second from a 32768 Hz crystal. The length of a second is trimmed digitally by two numbers. A coarse divisor P sets the base count per second. A fractional term Q stretches some of the seconds in each four-second frame by one count. The average rate can therefore be moved in steps of one part in 4·P+Q. With the zero-adjustment setting (P = 0x10000, Q = 0) a frame is 262144 counts. A step of one count in the combined value 4·P+Q is then about 3.8 ppm, and the usable span is about ±988 ppm. For example, a combined value of 0x40103 splits into P = 0x10040 and Q = 3.

Trim values from the host go into shadow registers first. A hold control (`trim_hold`) is raised while software writes. When it is released (a high-to-low change), the shadow contents become pending. The counters take up the pending values at the next second boundary, so no second in progress is cut short or stretched. Two test waveforms support rate measurement: a quarter-duty pulse once per second, and a pulse that marks the first second of every four-second frame.

Internally, a trim-update state machine has two states. In TRIM_IDLE nothing is pending; a release of `trim_hold` moves it to TRIM_ARMED. TRIM_ARMED stays put on a further release, which replaces the pending values, and returns to TRIM_IDLE at the next second boundary, where the values are applied. The second counter has a pulse-phase machine with two states. PH_MARK is entered at every second boundary and at reset. It moves to PH_SPACE when the first quarter of the second has elapsed.

Top module: `rtc_frac_tick`

## Requirements
- R1: A synchronous reset (`rst` high) loads P and Q with their parameter defaults, clears the count, and sets the frame index to 0. While reset is held, and in the first cycle after it, `sec_strobe`, `frame_strobe`, `pulse_1s` and `pulse_4s` are all 1.
- R2: A second whose frame index i (0 to 3) is below Q lasts P+1 cycles. Every other second lasts P cycles, so the longer seconds come first in the frame.
- R3: A four-second frame, measured from one `frame_strobe` to the next, lasts 4·P+Q cycles.
- R4: `sec_strobe` is 1 for exactly the first cycle of every second.
- R5: `pulse_1s` is 1 for the first floor(L/4) cycles of every second of length L, and 0 for the rest (P is at least 4).
- R6: `pulse_4s` is 1 for the whole second with frame index 0 and 0 for the other three.
- R7: A write (`host_wr` high) stores `host_p`/`host_q` in the shadow registers only. While `trim_hold` has no high-to-low change, second lengths do not change.
- R8: A high-to-low change of `trim_hold` copies the shadow values to pending. The second in progress keeps its length, and the new P/Q govern from the next second on. A further release before that boundary replaces the pending values.
- R9: Applying new trim values does not realign the frame. The frame index keeps counting, and `frame_strobe` is 1 only in the first cycle of a second with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-rate clock (both crystal edges) |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Write strobe for the shadow trim registers |
| host_p | input | 17 | Coarse divisor P to store in the shadow register |
| host_q | input | 2 | Fractional term Q to store in the shadow register |
| trim_hold | input | 1 | Hold control; its high-to-low change arms the shadow values |
| sec_strobe | output | 1 | One-cycle strobe at the start of every second |
| frame_strobe | output | 1 | One-cycle strobe at the start of every four-second frame |
| pulse_1s | output | 1 | Quarter-duty test pulse, period one second |
| pulse_4s | output | 1 | Test pulse covering the first second of each frame |

## Verification
The counter is run with Q at 0, 1, 2 and 3 and several values of P. Q = 0 shows whether any stretch leaks in. Q = 1 and Q = 2 show whether the stretched seconds are the leading ones and how many there are. Q = 3 together with the frame total shows whether the index comparison is off by one. Trim changes are made with the hold released at the very start of a second, written while the hold stays high, and re-armed twice within one second. These cases separate the shadow, pending and applied values, and show whether the frame index survives an update.

// File: rtl/rtc_frac_pkg.sv
package rtc_frac_pkg;

    // Trim-update sequencing
    typedef enum logic {
        TRIM_IDLE,
        TRIM_ARMED
    } trim_state_e;

    // Quarter-duty pulse phase within a second
    typedef enum logic {
        PH_MARK,
        PH_SPACE
    } pulse_phase_e;

endpackage

// File: rtl/rtc_trim_shadow.sv
module rtc_trim_shadow
    import rtc_frac_pkg::*;
#(
    parameter int P_W   = 17,
    parameter int Q_W   = 2,
    parameter int DEF_P = 65536,
    parameter int DEF_Q = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [P_W-1:0] host_p,
    input  logic [Q_W-1:0] host_q,
    input  logic           trim_hold,
    input  logic           sec_end,
    output logic [P_W-1:0] pend_p,
    output logic [Q_W-1:0] pend_q,
    output logic           apply,
    output logic           armed
);

    localparam logic [P_W-1:0] RST_P = P_W'(DEF_P);
    localparam logic [Q_W-1:0] RST_Q = Q_W'(DEF_Q);

    trim_state_e    state, state_nxt;
    logic [P_W-1:0] sh_p;
    logic [Q_W-1:0] sh_q;
    logic           hold_d;
    logic           release_evt;

    assign release_evt = hold_d & ~trim_hold;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TRIM_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            TRIM_IDLE: begin
                if (release_evt) state_nxt = TRIM_ARMED;
            end
            TRIM_ARMED: begin
                if (release_evt)  state_nxt = TRIM_ARMED;
                else if (sec_end) state_nxt = TRIM_IDLE;
            end
            default: state_nxt = TRIM_IDLE;
        endcase
    end

    // Outputs of the update machine
    always_comb begin
        apply = 1'b0;
        armed = 1'b0;
        unique case (state)
            TRIM_IDLE: begin
                apply = 1'b0;
                armed = 1'b0;
            end
            TRIM_ARMED: begin
                apply = sec_end;
                armed = 1'b1;
            end
            default: begin
                apply = 1'b0;
                armed = 1'b0;
            end
        endcase
    end

    // Shadow and pending storage
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_p   <= RST_P;
            sh_q   <= RST_Q;
            pend_p <= RST_P;
            pend_q <= RST_Q;
            hold_d <= 1'b0;
        end else begin
            hold_d <= trim_hold;
            if (release_evt) begin
                pend_p <= sh_p;
                pend_q <= sh_q;
            end
            if (host_wr) begin
                sh_p <= host_p;
                sh_q <= host_q;
            end
        end
    end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_frac_pkg::*;
#(
    parameter int P_W   = 17,
    parameter int Q_W   = 2,
    parameter int DEF_P = 65536,
    parameter int DEF_Q = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           apply,
    input  logic [P_W-1:0] new_p,
    input  logic [Q_W-1:0] new_q,
    output logic           sec_end,
    output logic [P_W-1:0] cur_p,
    output logic [Q_W-1:0] cur_q,
    output logic           sec_strobe,
    output logic           frame_strobe,
    output logic           pulse_1s,
    output logic           pulse_4s
);

    localparam int CW = P_W + 1;

    pulse_phase_e   phase, phase_nxt;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  sec_len;
    logic [CW-1:0]  quarter;
    logic [Q_W-1:0] idx;
    logic           stretch;

    always_comb begin
        stretch = (idx < cur_q);
        sec_len = CW'(cur_p) + CW'(stretch);
        quarter = sec_len >> 2;
        sec_end = (cnt == sec_len - CW'(1));
    end

    // Count, frame index and working trim
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            idx   <= '0;
            cur_p <= P_W'(DEF_P);
            cur_q <= Q_W'(DEF_Q);
        end else if (sec_end) begin
            cnt <= '0;
            idx <= idx + Q_W'(1);
            if (apply) begin
                cur_p <= new_p;
                cur_q <= new_q;
            end
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Pulse phase register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_MARK;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_MARK: begin
                if (sec_end)                      phase_nxt = PH_MARK;
                else if (cnt == quarter - CW'(1)) phase_nxt = PH_SPACE;
            end
            PH_SPACE: begin
                if (sec_end) phase_nxt = PH_MARK;
            end
            default: phase_nxt = PH_MARK;
        endcase
    end

    // Output decode
    always_comb begin
        sec_strobe   = (cnt == '0);
        frame_strobe = (cnt == '0) && (idx == '0);
        pulse_4s     = (idx == '0);
        pulse_1s     = 1'b0;
        unique case (phase)
            PH_MARK:  pulse_1s = 1'b1;
            PH_SPACE: pulse_1s = 1'b0;
            default:  pulse_1s = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_frac_tick.sv
module rtc_frac_tick #(
    parameter int P_W   = 17,
    parameter int Q_W   = 2,
    parameter int DEF_P = 65536,
    parameter int DEF_Q = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [P_W-1:0] host_p,
    input  logic [Q_W-1:0] host_q,
    input  logic           trim_hold,
    output logic           sec_strobe,
    output logic           frame_strobe,
    output logic           pulse_1s,
    output logic           pulse_4s
);

    logic           sec_end;
    logic           apply;
    logic           armed;
    logic [P_W-1:0] pend_p;
    logic [Q_W-1:0] pend_q;
    logic [P_W-1:0] cur_p;
    logic [Q_W-1:0] cur_q;

    rtc_trim_shadow #(
        .P_W  (P_W),
        .Q_W  (Q_W),
        .DEF_P(DEF_P),
        .DEF_Q(DEF_Q)
    ) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .host_wr  (host_wr),
        .host_p   (host_p),
        .host_q   (host_q),
        .trim_hold(trim_hold),
        .sec_end  (sec_end),
        .pend_p   (pend_p),
        .pend_q   (pend_q),
        .apply    (apply),
        .armed    (armed)
    );

    rtc_sec_counter #(
        .P_W  (P_W),
        .Q_W  (Q_W),
        .DEF_P(DEF_P),
        .DEF_Q(DEF_Q)
    ) u_count (
        .clk         (clk),
        .rst         (rst),
        .apply       (apply),
        .new_p       (pend_p),
        .new_q       (pend_q),
        .sec_end     (sec_end),
        .cur_p       (cur_p),
        .cur_q       (cur_q),
        .sec_strobe  (sec_strobe),
        .frame_strobe(frame_strobe),
        .pulse_1s    (pulse_1s),
        .pulse_4s    (pulse_4s)
    );

endmodule

// File: rtl/rtc_frac_tick_chk.sv
module rtc_frac_tick_chk #(
    parameter int P_W = 17,
    parameter int Q_W = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           sec_strobe,
    input logic           frame_strobe,
    input logic           pulse_1s,
    input logic           pulse_4s,
    input logic           armed,
    input logic [P_W-1:0] cur_p,
    input logic [Q_W-1:0] cur_q
);

    // R9: a frame start is always also a second start
    a_r9_frame_in_sec: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> sec_strobe);

    // R6: frame start lies inside the marked second
    a_r6_frame_marked: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> pulse_4s);

    // R6: the four-second pulse changes only at a second start
    a_r6_p4_steady: assert property (@(posedge clk) disable iff (rst)
        !sec_strobe |-> $stable(pulse_4s));

    // R5: every second opens with the quarter pulse high
    a_r5_pulse_opens: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |-> pulse_1s);

    // R5: the quarter pulse rises only at a second start
    a_r5_pulse_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_1s) |-> sec_strobe);

    // R8: working trim changes only at a second start
    a_r8_trim_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !sec_strobe |-> ($stable(cur_p) && $stable(cur_q)));

    // R8: working trim changes only after an arming release
    a_r8_trim_needs_arm: assert property (@(posedge clk) disable iff (rst)
        ((cur_p != $past(cur_p)) || (cur_q != $past(cur_q))) |-> $past(armed));

endmodule

bind rtc_frac_tick rtc_frac_tick_chk #(
    .P_W(P_W),
    .Q_W(Q_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_strobe  (sec_strobe),
    .frame_strobe(frame_strobe),
    .pulse_1s    (pulse_1s),
    .pulse_4s    (pulse_4s),
    .armed       (armed),
    .cur_p       (cur_p),
    .cur_q       (cur_q)
);

// File: tb/tb_rtc_frac_tick.sv
module tb_rtc_frac_tick;

    localparam int P_W = 17;
    localparam int Q_W = 2;
    localparam int DP  = 16;
    localparam int DQ  = 0;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           host_wr = 1'b0;
    logic [P_W-1:0] host_p = '0;
    logic [Q_W-1:0] host_q = '0;
    logic           trim_hold = 1'b0;
    logic           sec_strobe, frame_strobe, pulse_1s, pulse_4s;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_frac_tick #(.P_W(P_W), .Q_W(Q_W), .DEF_P(DP), .DEF_Q(DQ)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_p(host_p),
        .host_q(host_q), .trim_hold(trim_hold), .sec_strobe(sec_strobe),
        .frame_strobe(frame_strobe), .pulse_1s(pulse_1s), .pulse_4s(pulse_4s)
    );

    // Behavioural reference model
    int m_p = DP, m_q = DQ, m_pos = 0, m_sec = 0;
    int m_shp = DP, m_shq = DQ, m_pp = DP, m_pq = DQ;
    bit m_armed = 0, m_hprev = 0;

    function automatic int model_len();
        return m_p + (((m_sec % 4) < m_q) ? 1 : 0);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int  len;
        bit  fall;
        started = 1;
        if (rst) begin
            m_p = DP; m_q = DQ; m_pos = 0; m_sec = 0;
            m_shp = DP; m_shq = DQ; m_pp = DP; m_pq = DQ;
            m_armed = 0; m_hprev = 0;
        end else begin
            len  = model_len();
            fall = m_hprev && !trim_hold;
            if (m_pos == len - 1) begin
                m_pos = 0;
                m_sec++;
                if (m_armed) begin
                    m_p = m_pp; m_q = m_pq; m_armed = 0;
                end
            end else begin
                m_pos++;
            end
            if (fall) begin
                m_pp = m_shp; m_pq = m_shq; m_armed = 1;
            end
            if (host_wr) begin
                m_shp = int'(host_p); m_shq = int'(host_q);
            end
            m_hprev = trim_hold;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        int len;
        if (started && !done) begin
            len = model_len();
            check("R4 sec_strobe", int'(sec_strobe), int'(m_pos == 0));
            check("R9 frame_strobe", int'(frame_strobe), int'(m_pos == 0 && (m_sec % 4) == 0));
            check("R5 pulse_1s", int'(pulse_1s), int'(m_pos < len / 4));
            check("R6 pulse_4s", int'(pulse_4s), int'((m_sec % 4) == 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!sec_strobe);
    endtask

    // Called on a negedge where a second starts; returns its length and mark count
    task automatic measure_sec(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            if (pulse_1s) hi++;
            @(negedge clk);
            len++;
        end while (!sec_strobe);
    endtask

    task automatic measure_frame(string pre, int ep, int eq);
        int total = 0;
        while (!frame_strobe) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            int l, h;
            measure_sec(l, h);
            check($sformatf("%s R2 second %0d length", pre, k), l, ep + ((k < eq) ? 1 : 0));
            total += l;
        end
        check($sformatf("%s R3 frame length", pre), total, 4 * ep + eq);
    endtask

    task automatic write_trim(int p, int q);
        @(negedge clk);
        host_wr = 1'b1;
        host_p  = P_W'(p);
        host_q  = Q_W'(q);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    initial begin
        int l, h, n;
        repeat (3) @(negedge clk);
        check("R1 sec_strobe in reset", int'(sec_strobe), 1);
        check("R1 frame_strobe in reset", int'(frame_strobe), 1);
        check("R1 pulse_1s in reset", int'(pulse_1s), 1);
        check("R1 pulse_4s in reset", int'(pulse_4s), 1);
        rst = 1'b0;
        measure_frame("R1 default", DP, DQ);

        // R7: shadow writes with the hold kept high change nothing
        @(negedge clk);
        trim_hold = 1'b1;
        write_trim(20, 3);
        measure_frame("R7 held", DP, DQ);

        // R8: release at a second start; current second keeps old length
        wait_strobe();
        trim_hold = 1'b0;
        measure_sec(l, h);
        check("R8 second in progress keeps old length", l, DP);
        measure_frame("R8 q3", 20, 3);

        // Q = 1
        @(negedge clk);
        trim_hold = 1'b1;
        write_trim(18, 1);
        @(negedge clk);
        trim_hold = 1'b0;
        wait_strobe();
        wait_strobe();
        measure_frame("R2 q1", 18, 1);

        // Q = 2
        @(negedge clk);
        trim_hold = 1'b1;
        write_trim(17, 2);
        @(negedge clk);
        trim_hold = 1'b0;
        wait_strobe();
        wait_strobe();
        measure_frame("R2 q2", 17, 2);

        // R8: second release inside one second replaces pending values
        wait_strobe();
        trim_hold = 1'b1;
        write_trim(30, 1);
        @(negedge clk);
        trim_hold = 1'b0;
        @(negedge clk);
        trim_hold = 1'b1;
        write_trim(22, 0);
        @(negedge clk);
        trim_hold = 1'b0;
        wait_strobe();
        measure_sec(l, h);
        check("R8 replaced pending length", l, 22);
        check("R5 mark cycles per second", h, 22 / 4);
        measure_frame("R8 replaced", 22, 0);

        // R6: pulse_4s covers exactly the first second of a frame
        while (!frame_strobe) @(negedge clk);
        n = 0;
        while (pulse_4s) begin
            n++;
            @(negedge clk);
        end
        check("R6 four-second pulse width", n, 22);

        // R1: reset in mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 sec_strobe after mid-run reset", int'(sec_strobe), 1);
        rst = 1'b0;
        measure_frame("R1 after reset", DP, DQ);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule